// File: doc/BRIEF.md
# Chunk-Serial Multi-Operand Wide Adder

This block adds several wide unsigned numbers that reach it over a single narrow stream. Each operand is split into fixed-width chunks. The chunks of one operand arrive back to back, lowest chunk first, and the next operand starts only after the current one is complete. With the default parameters the block sums four 256-bit operands through a 32-bit data path. The result wraps modulo 2^256, and the carry out of the top chunk is dropped.

Inside, a cascade of adder stages does the work. Stage s holds the partial sum of operands 0 to s-1 in a small chunk buffer. When chunk i of operand s arrives, stage s adds it to the buffered chunk i and to the carry it kept from chunk i-1. It then passes the new partial chunk to the next stage through a register. Every stage keeps its own carry, so several chunks of a sum are in flight across the stages at once. The last stage produces the result stream: one chunk per cycle, lowest first, with a marker on the top chunk.

The stream may pause: a beat with the valid input low counts for nothing. Sums may follow one another with no idle cycle in between.

Top module: `csa_multi_adder`

## Requirements
- R1: A synchronous active-high reset clears the output valid flag on the next clock edge. The next valid beat after reset is taken as chunk 0 of operand 0 of a new sum.
- R2: The block counts input beats. Chunk index = number of valid beats modulo NUM_CHUNKS. The operand index advances after chunk NUM_CHUNKS-1 and wraps from NUM_OPS-1 to 0, which starts a new sum.
- R3: Result chunk i equals bits [i*CHUNK_W +: CHUNK_W] of the sum of all NUM_OPS operands, taken modulo 2^(CHUNK_W*NUM_CHUNKS).
- R4: A carry out of chunk i is added into chunk i+1 of the same stage. A carry must be able to travel through every chunk, for example in all-ones + 1.
- R5: The carry into chunk 0 is always zero, so the top carry of one sum never reaches the next sum.
- R6: Result chunks come out lowest first, one per valid output cycle. `sum_last` is high only together with chunk NUM_CHUNKS-1.
- R7: Result chunk i is valid exactly one clock after the beat that carries chunk i of the last operand.
- R8: A cycle with `in_valid` low changes neither the beat count nor any partial sum. When the last operand's chunk is not being presented, the output valid flag is low.
- R9: Sums may be presented back to back with no idle cycle, and each one yields its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input chunk is present this cycle |
| in_data | input | CHUNK_W | Input chunk |
| sum_valid | output | 1 | Result chunk valid |
| sum_data | output | CHUNK_W | Result chunk |
| sum_last | output | 1 | Result chunk is the top chunk of the sum |

## Verification
A lost or stuck inter-chunk carry, or a misplaced buffer entry, shows up as a wrong result chunk one clock after the last operand's chunk. The sum itself stays correct in the chunks below the fault. A carry that is not cleared shows up only in chunk 0 of the next sum, so the bench places a small sum right after an all-ones sum. A wrong beat count moves `sum_valid` or `sum_last` to the wrong cycle. The reference model compares the outputs on every clock, so any such fault is reported in the cycle where it first appears.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int CHUNK_W_DEF    = 32;
  localparam int NUM_CHUNKS_DEF = 8;
  localparam int NUM_OPS_DEF    = 4;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/csa_beat_tracker.sv
module csa_beat_tracker #(
  parameter int NUM_CHUNKS = csa_pkg::NUM_CHUNKS_DEF,
  parameter int NUM_OPS    = csa_pkg::NUM_OPS_DEF,
  localparam int CIW = csa_pkg::idx_bits(NUM_CHUNKS),
  localparam int OIW = csa_pkg::idx_bits(NUM_OPS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic [CIW-1:0] chunk_idx,
  output logic [OIW-1:0] op_idx
);
  localparam logic [CIW-1:0] LAST_CHUNK = CIW'(NUM_CHUNKS - 1);
  localparam logic [OIW-1:0] LAST_OP    = OIW'(NUM_OPS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      chunk_idx <= '0;
      op_idx    <= '0;
    end else if (in_valid) begin
      if (chunk_idx == LAST_CHUNK) begin
        chunk_idx <= '0;
        op_idx    <= (op_idx == LAST_OP) ? '0 : op_idx + OIW'(1);
      end else begin
        chunk_idx <= chunk_idx + CIW'(1);
      end
    end
  end

  AST_CHUNK_WRAP: assert property (@(posedge clk) disable iff (rst)
    in_valid && chunk_idx == LAST_CHUNK |=> chunk_idx == '0) else $error("chunk wrap"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(chunk_idx) && $stable(op_idx)) else $error("idle moved count"); // R8
endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
  parameter int CHUNK_W    = csa_pkg::CHUNK_W_DEF,
  parameter int NUM_CHUNKS = csa_pkg::NUM_CHUNKS_DEF,
  localparam int CIW = csa_pkg::idx_bits(NUM_CHUNKS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_valid,
  input  logic [CIW-1:0]     up_idx,
  input  logic [CHUNK_W-1:0] up_data,
  input  logic               take,
  input  logic [CIW-1:0]     take_idx,
  input  logic [CHUNK_W-1:0] take_data,
  output logic               out_valid,
  output logic               out_last,
  output logic [CIW-1:0]     out_idx,
  output logic [CHUNK_W-1:0] out_data
);
  localparam logic [CIW-1:0] LAST_CHUNK = CIW'(NUM_CHUNKS - 1);

  logic [CHUNK_W-1:0] pbuf [NUM_CHUNKS];
  logic               carry_q;
  logic               carry_in;
  logic [CHUNK_W:0]   add_w;

  // chunk 0 never sees a carry: each sum starts clean
  always_comb begin
    carry_in = (take_idx != '0) & carry_q;
    add_w    = {1'b0, pbuf[take_idx]} + {1'b0, take_data} + {{CHUNK_W{1'b0}}, carry_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CHUNKS; k++) pbuf[k] <= '0;
    end else if (up_valid) begin
      pbuf[up_idx] <= up_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q   <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      out_last  <= take && (take_idx == LAST_CHUNK);
      if (take) begin
        carry_q  <= add_w[CHUNK_W];
        out_idx  <= take_idx;
        out_data <= add_w[CHUNK_W-1:0];
      end
    end
  end

  AST_STAGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !take |=> !out_valid) else $error("stage output without input"); // R8
  AST_STAGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid && out_idx == $past(take_idx)) else $error("stage latency"); // R7
endmodule

// File: rtl/csa_multi_adder.sv
module csa_multi_adder #(
  parameter int CHUNK_W    = csa_pkg::CHUNK_W_DEF,
  parameter int NUM_CHUNKS = csa_pkg::NUM_CHUNKS_DEF,
  parameter int NUM_OPS    = csa_pkg::NUM_OPS_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [CHUNK_W-1:0] in_data,
  output logic               sum_valid,
  output logic [CHUNK_W-1:0] sum_data,
  output logic               sum_last
);
  localparam int CIW = csa_pkg::idx_bits(NUM_CHUNKS);
  localparam int OIW = csa_pkg::idx_bits(NUM_OPS);

  logic [CIW-1:0] chunk_idx;
  logic [OIW-1:0] op_idx;

  logic               lk_valid [NUM_OPS];
  logic               lk_last  [NUM_OPS];
  logic [CIW-1:0]     lk_idx   [NUM_OPS];
  logic [CHUNK_W-1:0] lk_data  [NUM_OPS];

  csa_beat_tracker #(.NUM_CHUNKS(NUM_CHUNKS), .NUM_OPS(NUM_OPS)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .chunk_idx(chunk_idx), .op_idx(op_idx)
  );

  // link 0 is the raw first operand, fed straight into stage 1's buffer
  always_comb begin
    lk_valid[0] = in_valid && (op_idx == '0);
    lk_last[0]  = 1'b0;
    lk_idx[0]   = chunk_idx;
    lk_data[0]  = in_data;
  end

  for (genvar s = 1; s < NUM_OPS; s++) begin : g_stage
    logic take_s;
    assign take_s = in_valid && (op_idx == OIW'(s));
    csa_stage #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_stage (
      .clk(clk), .rst(rst),
      .up_valid(lk_valid[s-1]), .up_idx(lk_idx[s-1]), .up_data(lk_data[s-1]),
      .take(take_s), .take_idx(chunk_idx), .take_data(in_data),
      .out_valid(lk_valid[s]), .out_last(lk_last[s]),
      .out_idx(lk_idx[s]), .out_data(lk_data[s])
    );
  end

  assign sum_valid = lk_valid[NUM_OPS-1];
  assign sum_data  = lk_data[NUM_OPS-1];
  assign sum_last  = lk_last[NUM_OPS-1];

  AST_LAST_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    sum_last |-> sum_valid) else $error("last without valid"); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !sum_valid) else $error("valid after reset"); // R1
endmodule

// File: tb/csa_multi_adder_tb.sv
module csa_multi_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;
  localparam int NC = 8;
  localparam int NO = 4;
  localparam int W  = CW * NC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_data = '0;
  logic          sum_valid;
  logic [CW-1:0] sum_data;
  logic          sum_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_multi_adder #(.CHUNK_W(CW), .NUM_CHUNKS(NC), .NUM_OPS(NO)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .sum_valid(sum_valid), .sum_data(sum_data), .sum_last(sum_last)
  );

  int n_checks = 0;
  int n_fails  = 0;
  string cur_req = "R1";

  logic [W-1:0]  ops  [NO];
  logic [W-1:0]  stim [NO];
  int            m_chunk = 0;
  int            m_op    = 0;
  logic          exp_v = 1'b0;
  logic          exp_l = 1'b0;
  logic [CW-1:0] exp_d = '0;

  task automatic check_now();
    logic ok;
    n_checks++;
    if (exp_v) ok = sum_valid && sum_data == exp_d && sum_last == exp_l;
    else       ok = !sum_valid && !sum_last;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: got v=%0b d=%h l=%0b, expected v=%0b d=%h l=%0b",
               cur_req, sum_valid, sum_data, sum_last, exp_v, exp_d, exp_l);
    end
  endtask

  // one clock: check the previous cycle's result, then drive and predict
  task automatic beat(input logic v, input logic [CW-1:0] d);
    logic [W-1:0] acc;
    @(negedge clk);
    check_now();
    in_valid = v;
    in_data  = d;
    exp_v = 1'b0;
    exp_l = 1'b0;
    if (v) begin
      ops[m_op][m_chunk*CW +: CW] = d;
      if (m_op == NO - 1) begin
        acc = '0;
        for (int k = 0; k < NO; k++) acc = acc + ops[k];
        exp_v = 1'b1;
        exp_d = acc[m_chunk*CW +: CW];
        exp_l = (m_chunk == NC - 1);
      end
      m_chunk++;
      if (m_chunk == NC) begin
        m_chunk = 0;
        m_op = (m_op + 1) % NO;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    exp_v = 1'b0;
    exp_l = 1'b0;
    check_now();  // R1: output cleared while in reset
    @(negedge clk);
    rst = 1'b0;
    m_chunk = 0;
    m_op = 0;
  endtask

  task automatic send_stim(input bit gaps);
    for (int k = 0; k < NO; k++)
      for (int c = 0; c < NC; c++) begin
        beat(1'b1, stim[k][c*CW +: CW]);
        if (gaps) beat(1'b0, $urandom());
      end
  endtask

  task automatic rand_stim();
    for (int k = 0; k < NO; k++)
      for (int c = 0; c < NC; c++) stim[k][c*CW +: CW] = $urandom();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NO; k++) ops[k] = '0;
    cur_req = "R1";
    do_reset();
    beat(1'b0, '0);
    beat(1'b0, '0);

    cur_req = "R3/R6/R7 zeros";
    for (int k = 0; k < NO; k++) stim[k] = '0;
    send_stim(1'b0);

    cur_req = "R3/R9 random back-to-back";
    for (int n = 0; n < 6; n++) begin
      rand_stim();
      send_stim(1'b0);
    end

    cur_req = "R4 all-ones wrap";
    for (int k = 0; k < NO; k++) stim[k] = '1;
    send_stim(1'b0);

    cur_req = "R5 no carry leak";
    for (int k = 0; k < NO; k++) stim[k] = W'(k + 1);
    send_stim(1'b0);

    cur_req = "R4 ripple through all chunks";
    stim[0] = '1;
    stim[1] = W'(1);
    for (int k = 2; k < NO; k++) stim[k] = '0;
    send_stim(1'b0);

    cur_req = "R4 ripple late stage";
    for (int k = 0; k < NO - 1; k++) stim[k] = '0;
    stim[0] = '1;
    stim[NO-1] = W'(1);
    send_stim(1'b0);

    cur_req = "R8/R2 idle gaps";
    for (int n = 0; n < 2; n++) begin
      rand_stim();
      send_stim(1'b1);
    end
    for (int i = 0; i < 3; i++) beat(1'b0, '1);

    cur_req = "R1 mid-sum reset";
    rand_stim();
    for (int c = 0; c < NC + 3; c++) beat(1'b1, $urandom());
    do_reset();
    cur_req = "R1/R3 after reset";
    rand_stim();
    send_stim(1'b0);

    cur_req = "R8 tail idle";
    for (int i = 0; i < 4; i++) beat(1'b0, $urandom());

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule